// File: doc/BRIEF.md
# Per-Scan Background Subtractor

This block removes a fixed background pattern from a stream of scans. Each scan is a run of signed 16-bit samples, up to `NPTS` long, framed by a start-of-scan marker on its first sample and a last marker on its final one. The block keeps one background vector of `NPTS` signed elements. It subtracts the element whose position matches the sample's position in the scan. The same vector is applied to every scan until software replaces it, which suppresses artifacts that stay put from one scan to the next.

Software fills the vector by writing every element, one after another, to a single data address. A second address holds the enable bit. Writing that address also rewinds the fill position to element 0, which gives software a clean way to start a fresh load. The enable bit takes effect only at a scan boundary, so no scan comes out partly corrected. After reset the block sweeps zeros through the whole vector. Until a vector is loaded, subtraction is then a no-op.

Top module: `scan_bg_sub`

## Requirements
- R1: While reset is high and after it falls, `out_valid` is low and the enable bit is 0. After reset, the block spends `NPTS` cycles writing zero into every vector element. Data-address writes that arrive during that sweep are dropped, so an enabled scan afterwards comes out unchanged.
- R2: Register address 0 is the vector data port. Address 1 is the control register, with bit 0 as the enable. A write to any other address changes neither the vector, the fill position nor the enable.
- R3: Successive data-port writes fill elements 0, 1, 2 and onward. Any control-register write rewinds the fill position to element 0. After element `NPTS-1` the fill position wraps to element 0.
- R4: The sample that carries the start-of-scan marker uses element 0. Each later valid sample uses the next element. Cycles with `in_valid` low do not advance the position, and a new start-of-scan marker restarts at 0 even if no last marker came first.
- R5: When subtraction is active, `out_data = in_data - vector[pos]`. The difference is formed at 17 bits and clamped to the range -32768..32767.
- R6: When subtraction is inactive for a scan, `out_data` equals `in_data` bit for bit.
- R7: The enable bit is sampled on the start-of-scan sample, and that value governs the whole scan. A change to the enable bit in the middle of a scan has no effect until the next start-of-scan.
- R8: Each valid input sample yields exactly one valid output sample two clock cycles later, with its start-of-scan and last markers carried along. No output is valid without a matching input.
- R9: A loaded vector stays in force for every later scan until it is overwritten or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_sos | input | 1 | Input sample is the first of a scan |
| in_last | input | 1 | Input sample is the last of a scan |
| in_data | input | DATA_W | Signed input sample |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address (0 vector data, 1 control) |
| reg_wdata | input | DATA_W | Register write data |
| out_valid | output | 1 | Output sample valid |
| out_sos | output | 1 | Output sample is the first of a scan |
| out_last | output | 1 | Output sample is the last of a scan |
| out_data | output | DATA_W | Signed corrected sample |

## Verification
The hardest case to reach from the ports is a control write that lands in the middle of a running scan. The same cycle both flips the enable and rewinds the fill position, while the scan's own enable must stay frozen. The stimulus sends a sample and a control write in the same cycle, partway through a disabled scan. It then checks that the rest of that scan passes through unchanged and that the next scan is corrected. The fill-position wrap is reached by writing `NPTS+3` elements after a rewind, so the last three writes land on elements 0 to 2. Saturation is reached by putting the extreme values in the first two vector and data positions.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef struct packed {
    logic sos;
    logic last;
  } bgs_mark_t;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_VEC  = 2'd1,
    REG_CTL  = 2'd2
  } bgs_reg_e;
endpackage

// File: rtl/bgs_ctrl.sv
module bgs_ctrl
  import bgs_pkg::*;
#(
  parameter int NPTS     = 2048,
  parameter int DW       = 16,
  parameter int RAW      = 4,
  parameter int VEC_ADDR = 0,
  parameter int CTL_ADDR = 1,
  localparam int AW      = $clog2(NPTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          en,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam logic [AW-1:0] LAST = AW'(NPTS - 1);

  bgs_reg_e      sel;
  logic [AW-1:0] ld_ptr;
  logic [AW-1:0] clr_ptr;
  logic          clr_busy;

  always_comb begin
    sel = REG_NONE;
    if (reg_we && reg_addr == RAW'(VEC_ADDR)) sel = REG_VEC;
    else if (reg_we && reg_addr == RAW'(CTL_ADDR)) sel = REG_CTL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      ld_ptr   <= '0;
      clr_ptr  <= '0;
      clr_busy <= 1'b1;
    end else begin
      if (clr_busy) begin
        clr_ptr <= (clr_ptr == LAST) ? '0 : clr_ptr + AW'(1);
        if (clr_ptr == LAST) clr_busy <= 1'b0;
      end
      if (sel == REG_CTL) begin
        en     <= reg_wdata[0];
        ld_ptr <= '0;
      end else if (sel == REG_VEC && !clr_busy) begin
        ld_ptr <= (ld_ptr == LAST) ? '0 : ld_ptr + AW'(1);
      end
    end
  end

  assign mem_we    = clr_busy | (sel == REG_VEC);
  assign mem_waddr = clr_busy ? clr_ptr : ld_ptr;
  assign mem_wdata = clr_busy ? '0 : reg_wdata;

  p_ptr_home_r3: assert property (@(posedge clk) disable iff (rst)
    sel == REG_CTL |=> ld_ptr == '0);
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == REG_VEC && !clr_busy && ld_ptr == LAST) |=> ld_ptr == '0);
  p_clear_ends_r1: assert property (@(posedge clk) disable iff (rst)
    (clr_busy && clr_ptr == LAST) |=> !clr_busy);
  p_en_holds_r2: assert property (@(posedge clk) disable iff (rst)
    sel != REG_CTL |=> $stable(en));
endmodule

// File: rtl/bgs_mem.sv
module bgs_mem #(
  parameter int DEPTH = 2048,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bgs_pipe.sv
module bgs_pipe
  import bgs_pkg::*;
#(
  parameter int NPTS = 2048,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NPTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sos,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  input  logic          en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          out_valid,
  output logic          out_sos,
  output logic          out_last,
  output logic [DW-1:0] out_data
);
  localparam logic [AW-1:0] LAST = AW'(NPTS - 1);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [AW-1:0] idx_cnt;
  logic          scan_en;
  logic          s1_valid;
  logic          s1_en;
  logic [DW-1:0] s1_data;
  bgs_mark_t     s1_mark;
  logic [DW:0]   diff;
  logic [DW-1:0] sat;

  assign rd_addr = in_sos ? '0 : idx_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_cnt  <= '0;
      scan_en  <= 1'b0;
      s1_valid <= 1'b0;
      s1_en    <= 1'b0;
      s1_data  <= '0;
      s1_mark  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        if (in_sos) begin
          idx_cnt <= AW'(1);
          scan_en <= en;
        end else begin
          idx_cnt <= (idx_cnt == LAST) ? '0 : idx_cnt + AW'(1);
        end
        s1_en   <= in_sos ? en : scan_en;
        s1_data <= in_data;
        s1_mark <= '{sos: in_sos, last: in_last};
      end
    end
  end

  always_comb begin
    diff = {s1_data[DW-1], s1_data} - {rd_data[DW-1], rd_data};
    if (diff[DW] != diff[DW-1]) sat = diff[DW] ? SMIN : SMAX;
    else                        sat = diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sos   <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_sos  <= s1_mark.sos;
        out_last <= s1_mark.last;
        out_data <= s1_en ? sat : s1_data;
      end
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(idx_cnt));
  p_scan_en_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sos) |=> $stable(scan_en));
  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_en) |=> out_data == $past(s1_data));
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_en && !s1_data[DW-1] && rd_data[DW-1]) |=> !out_data[DW-1]);
  p_sat_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_en && s1_data[DW-1] && !rd_data[DW-1]) |=> out_data[DW-1]);
endmodule

// File: rtl/scan_bg_sub.sv
module scan_bg_sub #(
  parameter int NPTS     = 2048,
  parameter int DATA_W   = 16,
  parameter int REG_AW   = 4,
  parameter int VEC_ADDR = 0,
  parameter int CTL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sos,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              out_valid,
  output logic              out_sos,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data
);
  localparam int AW = $clog2(NPTS);

  logic              en;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_data;

  bgs_ctrl #(
    .NPTS(NPTS), .DW(DATA_W), .RAW(REG_AW),
    .VEC_ADDR(VEC_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .en(en), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  bgs_mem #(.DEPTH(NPTS), .DW(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  bgs_pipe #(.NPTS(NPTS), .DW(DATA_W)) u_pipe (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sos(in_sos), .in_last(in_last), .in_data(in_data),
    .en(en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_sos(out_sos), .out_last(out_last), .out_data(out_data)
  );
endmodule

// File: tb/tb_scan_bg_sub.sv
`timescale 1ns/1ps
module tb_scan_bg_sub;
  localparam int NPTS = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sos = 1'b0, in_last = 1'b0;
  logic [15:0] in_data = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        out_valid, out_sos, out_last;
  logic [15:0] out_data;

  scan_bg_sub dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sos(in_sos), .in_last(in_last),
    .in_data(in_data), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .out_valid(out_valid), .out_sos(out_sos), .out_last(out_last), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] bgm [NPTS];
  int  m_ptr = 0;
  bit  m_en = 0;
  bit  m_scan_en = 0;
  int  m_idx = 0;
  bit  m_clearing = 0;

  logic [17:0] eq[$];
  string       rq[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sat_sub(input logic [15:0] d, input logic [15:0] b);
    int x;
    x = int'($signed(d)) - int'($signed(b));
    if (x > 32767) x = 32767;
    if (x < -32768) x = -32768;
    return 16'(x);
  endfunction

  function automatic logic [15:0] bg_f(input int i);
    if (i == 0) return 16'h8000;
    if (i == 1) return 16'h7FFF;
    return 16'(i * 37 - 20000);
  endfunction

  function automatic logic [15:0] dat_f(input int i);
    if (i == 0) return 16'h7FFF;
    if (i == 1) return 16'h8000;
    return 16'(i * 101 + 3000);
  endfunction

  task automatic cyc(input bit v, input bit sos, input bit last, input logic [15:0] d,
                     input bit we, input logic [3:0] a, input logic [15:0] wd, input string req);
    bit eff;
    logic [15:0] e;
    @(negedge clk);
    in_valid = v; in_sos = sos; in_last = last; in_data = d;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    if (v) begin
      eff = sos ? m_en : m_scan_en;
      if (sos) begin m_scan_en = m_en; m_idx = 0; end
      e = eff ? sat_sub(d, bgm[m_idx]) : d;
      eq.push_back({sos, last, e});
      rq.push_back(req);
      m_idx = (m_idx + 1) % NPTS;
    end
    if (we) begin
      if (a == 4'd0 && !m_clearing) begin
        bgm[m_ptr] = wd;
        m_ptr = (m_ptr + 1) % NPTS;
      end else if (a == 4'd1) begin
        m_en = wd[0];
        m_ptr = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, '0, '0, "");
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] wd);
    cyc(0, 0, 0, '0, 1, a, wd, "");
  endtask

  task automatic scan(input int n, input int base, input int gap, input string req);
    for (int i = 0; i < n; i++) begin
      cyc(1, i == 0, i == n - 1, dat_f(base + i), 0, '0, '0, req);
      if (gap > 0 && (i % 3) == 1) idle(gap);
    end
  endtask

  task automatic drain(input string req);
    idle(4);
    chk(eq.size() == 0, req, "outputs still missing", eq.size(), 0);
    eq.delete(); rq.delete();
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (eq.size() == 0) begin
        chk(0, "R8", "output with no matching input", 1, 0);
      end else begin
        logic [17:0] x;
        string r;
        x = eq.pop_front();
        r = rq.pop_front();
        chk(out_data == x[15:0], r, "data", int'($signed(out_data)), int'($signed(x[15:0])));
        chk({out_sos, out_last} == x[17:16], "R8", "markers", int'({out_sos, out_last}), int'(x[17:16]));
      end
    end
  end

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < NPTS; i++) bgm[i] = '0;
    m_clearing = 1;
    for (int i = 0; i < 5; i++) wr(4'd0, 16'h1234);
    m_clearing = 0;
    idle(NPTS + 10);
    chk(out_valid == 1'b0, "R1", "out_valid idle after reset", int'(out_valid), 0);
    wr(4'd1, 16'h0001);
    scan(16, 40, 0, "R1");
    drain("R1");
  endtask

  task automatic t_load_full;
    wr(4'd1, 16'h0001);
    for (int i = 0; i < NPTS; i++) begin
      wr(4'd0, bg_f(i));
      if (i == 100) wr(4'd2, 16'h5555);
    end
    scan(NPTS, 0, 0, "R5");
    drain("R5");
    wr(4'd3, 16'h0000);
    scan(6, 0, 0, "R2");
    drain("R2");
  endtask

  task automatic t_persist;
    scan(8, 0, 0, "R9");
    scan(9, 0, 2, "R4");
    scan(5, 0, 0, "R4");
    cyc(1, 1, 0, dat_f(0), 0, '0, '0, "R4");
    for (int i = 1; i < 4; i++) cyc(1, 0, i == 3, dat_f(i), 0, '0, '0, "R4");
    drain("R9");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 3; i++) wr(4'd0, 16'h7777);
    wr(4'd1, 16'h0001);
    for (int i = 0; i < NPTS + 3; i++) wr(4'd0, (i >= NPTS) ? 16'(i * 211) : bg_f(i));
    scan(6, 0, 0, "R3");
    drain("R3");
  endtask

  task automatic t_disable;
    wr(4'd1, 16'h0000);
    scan(10, 0, 0, "R6");
    drain("R6");
  endtask

  task automatic t_midscan;
    for (int i = 0; i < 20; i++)
      cyc(1, i == 0, i == 19, dat_f(i), i == 5, 4'd1, 16'h0001, "R7");
    scan(6, 0, 0, "R7");
    drain("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_full();
    t_persist();
    t_wrap();
    t_disable();
    t_midscan();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule